// File: doc/BRIEF.md
# Vacuum Fluorescent Panel Grid Multiplex and Dimming Sequencer

This block drives a multiplexed vacuum fluorescent panel. It steps through the active digits one slot at a time. During each digit's slot it enables that digit's grid and presents the digit's segment pattern, which it fetches from a display memory through a read port. Every slot is split into sixteen equal sub-slots. A three-bit brightness code sets how many of those sub-slots the grid and segments stay lit. Each frame ends with one extra slot in which the panel is dark, so that a key scanner can use the segment lines as key sources.

The panel has eight pins that can act either as segments or as grids. When more digits are selected, fewer segments remain. The digit count is programmed from 4 to 12 through a mode code, and the new value takes effect at the next frame boundary. The block advances on a tick input that runs at the display oscillator rate. A frame strobe and a key-slot level tell the key scanner where the frame stands.

Top module: `vfd_grid_sequencer`

## Requirements
- R1: While reset is asserted, and after release until the first sub-slot boundary at which the display enable is high, `grid_o`, `seg_o`, `shared_o`, `frame_o` and `key_slot_o` are all 0. The brightness code held after reset is 0.
- R2: A sub-slot lasts `TICKS_PER_SUB` cycles in which `tick_i` is high. Cycles without a tick do not count toward it. A slot lasts 16 sub-slots. The grid, segment and shared outputs change only on the clock edge that ends a sub-slot.
- R3: With n active digits a frame has n+1 slots: digit slots 0 to n-1, then one key slot. `key_slot_o` is high for the whole key slot, and no grid and no segment is active during it. `frame_o` is high for exactly one clock when slot 0 begins.
- R4: Mode code m selects the digit count. Codes 0 to 7 select 4+m digits. Any code with bit 3 set selects 12 digits, and 12 is also the count after reset. The mode is sampled only when a new frame begins.
- R5: Dim codes 0 to 7 light the grid and segments for the first 1, 2, 4, 10, 11, 12, 13 or 14 sub-slots of a digit slot, respectively. The code is sampled at every sub-slot boundary.
- R6: Bit k of `grid_o` is active only in the slot of digit k. At most one bit of `grid_o` is active at any time.
- R7: In the slot of digit k, `seg_o[j]` equals bit j of the 24-bit word read at `mem_idx_o` = k. That word is bytes 3k, 3k+1 and 3k+2 from low to high, so bit 0 of byte 3k drives segment 1. The word is captured once, as the slot begins. Segment bits at index 28-n and above are 0. Outside the lit window all segment bits are 0.
- R8: Shared pin j (0 to 7) carries grid index 11-j when 11-j < n. Otherwise it carries `seg_o[16+j]`. Shared pin 7 is therefore the first pin to become a grid.
- R9: The display enable is sampled at sub-slot boundaries. While the sampled value is 0, every grid, segment and shared output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Advance strobe at the display oscillator rate |
| mode_i | input | 4 | Digit-count mode code |
| dim_i | input | 3 | Brightness code |
| disp_on_i | input | 1 | Display enable |
| mem_idx_o | output | 4 | Digit index presented to the display memory |
| mem_data_i | input | 24 | Three bytes of the addressed digit, lowest byte in bits 7:0 |
| grid_o | output | 12 | Logical grid enables, bit k for digit k |
| seg_o | output | 24 | Gated segment lines, bit j for segment j+1 |
| shared_o | output | 8 | Dual-role pins, either a grid or a segment |
| frame_o | output | 1 | One-clock pulse at the start of each frame |
| key_slot_o | output | 1 | High during the key-scan slot |

## Verification
Several updates can land on the same edge. Entering a new frame latches the mode, samples brightness and enable, and captures the first digit's memory word together. In the same cycle the memory can be rewritten and the mode, dim and enable inputs can change. Random stimulus rewrites memory on every cycle and changes the mode, dim code and enable at arbitrary moments, so these events regularly meet at frame and slot boundaries. A cycle-level reference model built from the requirements then judges every output on every cycle.

// File: rtl/vfd_seq_pkg.sv
package vfd_seq_pkg;
    localparam int unsigned MAX_DIG = 12;
    localparam int unsigned MIN_DIG = 4;
    localparam int unsigned NSEG    = 24;
    localparam int unsigned NSUB    = 16;
    localparam int unsigned NSHARE  = MAX_DIG - MIN_DIG;
    localparam int unsigned MODE_W  = 4;
    localparam int unsigned DIM_W   = 3;
    localparam int unsigned SLOT_W  = $clog2(MAX_DIG + 1);
    localparam int unsigned SUB_W   = $clog2(NSUB);
    localparam int unsigned WID_W   = SUB_W + 1;

    // digit count selected by a mode code
    function automatic logic [SLOT_W-1:0] digits_of(input logic [MODE_W-1:0] code);
        if (code[MODE_W-1]) return SLOT_W'(MAX_DIG);
        return SLOT_W'(MIN_DIG) + SLOT_W'(code[MODE_W-2:0]);
    endfunction
endpackage

// File: rtl/vfd_dim_lut.sv
module vfd_dim_lut
    import vfd_seq_pkg::*;
(
    input  logic [DIM_W-1:0] code_i,
    output logic [WID_W-1:0] width_o
);
    // lit sub-slots per slot; steep at the low end, fine steps near full on
    always_comb begin
        case (code_i)
            3'd0:    width_o = WID_W'(1);
            3'd1:    width_o = WID_W'(2);
            3'd2:    width_o = WID_W'(4);
            3'd3:    width_o = WID_W'(10);
            3'd4:    width_o = WID_W'(11);
            3'd5:    width_o = WID_W'(12);
            3'd6:    width_o = WID_W'(13);
            default: width_o = WID_W'(14);
        endcase
    end
endmodule

// File: rtl/vfd_seq_timebase.sv
module vfd_seq_timebase
    import vfd_seq_pkg::*;
#(
    parameter int unsigned TICKS_PER_SUB = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic [MODE_W-1:0] mode_i,
    output logic              bnd_o,
    output logic              entry_o,
    output logic [SLOT_W-1:0] nxt_slot_o,
    output logic [SLOT_W-1:0] nxt_ndig_o,
    output logic [SUB_W-1:0]  nxt_sub_o,
    output logic              frame_o,
    output logic              key_o
);
    localparam int unsigned DIV_W = (TICKS_PER_SUB > 1) ? $clog2(TICKS_PER_SUB) : 1;
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(TICKS_PER_SUB - 1);
    localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(NSUB - 1);

    typedef struct packed {
        logic [DIV_W-1:0]  div;
        logic [SUB_W-1:0]  sub;
        logic [SLOT_W-1:0] slot;
        logic [SLOT_W-1:0] ndig;
        logic              frame;
        logic              key;
    } tb_state_t;

    tb_state_t q, d;
    logic bnd, entry;

    always_comb begin
        d       = q;
        bnd     = 1'b0;
        entry   = 1'b0;
        d.frame = 1'b0;
        if (tick_i) begin
            if (q.div == DIV_LAST) begin
                d.div = '0;
                bnd   = 1'b1;
                if (q.sub == SUB_LAST) begin
                    d.sub = '0;
                    entry = 1'b1;
                    if (q.slot == q.ndig) begin
                        // key slot done: new frame, digit count reloaded here only
                        d.slot  = '0;
                        d.ndig  = digits_of(mode_i);
                        d.frame = 1'b1;
                    end else begin
                        d.slot = q.slot + 1'b1;
                    end
                end else begin
                    d.sub = q.sub + 1'b1;
                end
            end else begin
                d.div = q.div + 1'b1;
            end
        end
        d.key = (d.slot == d.ndig);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.ndig <= SLOT_W'(MAX_DIG);
        end else begin
            q <= d;
        end
    end

    assign bnd_o      = bnd;
    assign entry_o    = entry;
    assign nxt_slot_o = d.slot;
    assign nxt_ndig_o = d.ndig;
    assign nxt_sub_o  = d.sub;
    assign frame_o    = q.frame;
    assign key_o      = q.key;

    assert_frame_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        frame_o |=> !frame_o);
endmodule

// File: rtl/vfd_seq_drive.sv
module vfd_seq_drive
    import vfd_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bnd_i,
    input  logic              entry_i,
    input  logic [SLOT_W-1:0] nxt_slot_i,
    input  logic [SLOT_W-1:0] nxt_ndig_i,
    input  logic [SUB_W-1:0]  nxt_sub_i,
    input  logic [WID_W-1:0]  width_i,
    input  logic              on_i,
    input  logic [NSEG-1:0]   mem_data_i,
    output logic [SLOT_W-1:0] mem_idx_o,
    output logic [MAX_DIG-1:0] grid_o,
    output logic [NSEG-1:0]   seg_o,
    output logic [NSHARE-1:0] shared_o
);
    localparam int unsigned SEG_CW = $clog2(NSEG + MIN_DIG + 1);
    localparam int unsigned BASE_SEG = NSEG - NSHARE;

    typedef struct packed {
        logic [WID_W-1:0]   width;
        logic               on;
        logic [NSEG-1:0]    data;
        logic [MAX_DIG-1:0] grid;
        logic [NSEG-1:0]    seg;
        logic [NSHARE-1:0]  shared;
    } dr_state_t;

    dr_state_t q, d;
    logic digit_slot;
    logic win;
    logic [SEG_CW-1:0] seg_lim;

    assign digit_slot = (nxt_slot_i < nxt_ndig_i);
    assign seg_lim    = SEG_CW'(NSEG + MIN_DIG) - SEG_CW'(nxt_ndig_i);
    assign mem_idx_o  = digit_slot ? nxt_slot_i : '0;

    always_comb begin
        d = q;
        if (bnd_i) begin
            d.width = width_i;
            d.on    = on_i;
        end
        if (entry_i && digit_slot) d.data = mem_data_i;
        win = d.on && digit_slot && ({1'b0, nxt_sub_i} < d.width);
        for (int g = 0; g < MAX_DIG; g++)
            d.grid[g] = win && (nxt_slot_i == SLOT_W'(g));
        for (int k = 0; k < NSEG; k++)
            d.seg[k] = win && d.data[k] && (SEG_CW'(k) < seg_lim);
        for (int j = 0; j < NSHARE; j++) begin
            if (SLOT_W'(MAX_DIG - 1 - j) < nxt_ndig_i) d.shared[j] = d.grid[MAX_DIG-1-j];
            else                                       d.shared[j] = d.seg[BASE_SEG+j];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.width <= WID_W'(1);
        end else begin
            q <= d;
        end
    end

    assign grid_o   = q.grid;
    assign seg_o    = q.seg;
    assign shared_o = q.shared;

    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !bnd_i |=> ($stable(grid_o) && $stable(seg_o) && $stable(shared_o)));
    assert_grid_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grid_o));
    assert_off_dark_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(bnd_i) && !$past(on_i)) |-> (grid_o == '0 && seg_o == '0));
endmodule

// File: rtl/vfd_grid_sequencer.sv
module vfd_grid_sequencer
    import vfd_seq_pkg::*;
#(
    parameter int unsigned TICKS_PER_SUB = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick_i,
    input  logic [MODE_W-1:0]  mode_i,
    input  logic [DIM_W-1:0]   dim_i,
    input  logic               disp_on_i,
    output logic [SLOT_W-1:0]  mem_idx_o,
    input  logic [NSEG-1:0]    mem_data_i,
    output logic [MAX_DIG-1:0] grid_o,
    output logic [NSEG-1:0]    seg_o,
    output logic [NSHARE-1:0]  shared_o,
    output logic               frame_o,
    output logic               key_slot_o
);
    logic              bnd, entry;
    logic [SLOT_W-1:0] nxt_slot, nxt_ndig;
    logic [SUB_W-1:0]  nxt_sub;
    logic [WID_W-1:0]  width;

    vfd_seq_timebase #(.TICKS_PER_SUB(TICKS_PER_SUB)) u_timebase (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick_i),
        .mode_i     (mode_i),
        .bnd_o      (bnd),
        .entry_o    (entry),
        .nxt_slot_o (nxt_slot),
        .nxt_ndig_o (nxt_ndig),
        .nxt_sub_o  (nxt_sub),
        .frame_o    (frame_o),
        .key_o      (key_slot_o)
    );

    vfd_dim_lut u_dim (
        .code_i  (dim_i),
        .width_o (width)
    );

    vfd_seq_drive u_drive (
        .clk        (clk),
        .rst_n      (rst_n),
        .bnd_i      (bnd),
        .entry_i    (entry),
        .nxt_slot_i (nxt_slot),
        .nxt_ndig_i (nxt_ndig),
        .nxt_sub_i  (nxt_sub),
        .width_i    (width),
        .on_i       (disp_on_i),
        .mem_data_i (mem_data_i),
        .mem_idx_o  (mem_idx_o),
        .grid_o     (grid_o),
        .seg_o      (seg_o),
        .shared_o   (shared_o)
    );

    assert_key_dark_R3: assert property (@(posedge clk) disable iff (!rst_n)
        key_slot_o |-> (grid_o == '0 && seg_o == '0));
endmodule

// File: tb/vfd_grid_sequencer_tb_top.sv
module vfd_grid_sequencer_tb_top;
    localparam int TPS = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0;
    logic [3:0] mode = 4'd0;
    logic [2:0] dim = 3'd0;
    logic on = 1'b0;
    logic [3:0] mem_idx;
    logic [23:0] mem_data;
    logic [11:0] grid;
    logic [23:0] seg;
    logic [7:0] shared;
    logic frame, key;
    logic [7:0] mem [36];

    int checks = 0, fails = 0;
    int m_div, m_sub, m_slot, m_n, m_w;
    logic m_on, m_frame;
    logic [23:0] m_data;
    int cyc_g0 = 0, cyc_lit = 0;
    logic saw_frame = 1'b0;
    int len;

    always #10 clk = ~clk;

    vfd_grid_sequencer #(.TICKS_PER_SUB(TPS)) dut_i (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .mode_i(mode), .dim_i(dim),
        .disp_on_i(on), .mem_idx_o(mem_idx), .mem_data_i(mem_data),
        .grid_o(grid), .seg_o(seg), .shared_o(shared),
        .frame_o(frame), .key_slot_o(key)
    );

    always_comb begin
        int b;
        b = 3 * int'(mem_idx);
        if (b > 33) b = 0;
        mem_data = {mem[b+2], mem[b+1], mem[b]};
    end

    function automatic int f_nd(input logic [3:0] m);
        return m[3] ? 12 : 4 + int'(m[2:0]);
    endfunction

    function automatic int f_w(input logic [2:0] c);
        case (c)
            3'd0: return 1;   3'd1: return 2;   3'd2: return 4;   3'd3: return 10;
            3'd4: return 11;  3'd5: return 12;  3'd6: return 13;  default: return 14;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [23:0] act, input logic [23:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        m_div = 0; m_sub = 0; m_slot = 0; m_n = 12; m_w = 1;
        m_on = 1'b0; m_frame = 1'b0; m_data = '0;
    endtask

    // effect of the coming clock edge, from the inputs now applied
    task automatic model_edge();
        m_frame = 1'b0;
        if (tick) begin
            if (m_div == TPS - 1) begin
                m_div = 0;
                m_w = f_w(dim);
                m_on = on;
                if (m_sub == 15) begin
                    m_sub = 0;
                    if (m_slot == m_n) begin
                        m_slot = 0; m_n = f_nd(mode); m_frame = 1'b1;
                    end else m_slot++;
                    if (m_slot < m_n)
                        m_data = {mem[3*m_slot+2], mem[3*m_slot+1], mem[3*m_slot]};
                end else m_sub++;
            end else m_div++;
        end
    endtask

    task automatic check_outputs();
        logic [11:0] eg;
        logic [23:0] es;
        logic [7:0] esh;
        logic win;
        win = m_on && (m_slot < m_n) && (m_sub < m_w);
        for (int g = 0; g < 12; g++) eg[g] = win && (g == m_slot);
        for (int k = 0; k < 24; k++) es[k] = win && (k < 28 - m_n) && m_data[k];
        for (int j = 0; j < 8; j++) esh[j] = (11 - j < m_n) ? eg[11-j] : es[16+j];
        chk("R5 R6 grid enables", 24'(grid), 24'(eg));
        chk("R7 segment lines", seg, es);
        chk("R8 shared pins", 24'(shared), 24'(esh));
        chk("R3 frame strobe", 24'(frame), 24'(m_frame));
        chk("R3 key slot", 24'(key), 24'(m_slot == m_n));
        if (grid[0]) cyc_g0++;
        if (grid != '0 || seg != '0 || shared != '0) cyc_lit++;
        if (frame) saw_frame = 1'b1;
    endtask

    task automatic step(input logic t);
        tick = t;
        model_edge();
        @(negedge clk);
        check_outputs();
    endtask

    // runs whole tick periods (one tick then gap idle cycles) until a frame pulse
    task automatic run_to_frame(input int gap, output int n);
        n = 0;
        saw_frame = 1'b0;
        while (!saw_frame && n < 20000) begin
            step(1'b1); n++;
            for (int i = 0; i < gap; i++) begin step(1'b0); n++; end
        end
    endtask

    initial begin
        int scratch;
        void'($urandom(32'd4711));
        for (int i = 0; i < 36; i++) mem[i] = 8'($urandom);
        model_reset();
        repeat (3) @(negedge clk);
        chk("R1 reset grid", 24'(grid), 24'd0);
        chk("R1 reset segments", seg, 24'd0);
        chk("R1 reset shared", 24'(shared), 24'd0);
        chk("R1 reset frame/key", 24'({frame, key}), 24'd0);
        rst_n = 1'b1;
        on = 1'b1;
        mode = 4'd0;
        repeat (4) step(1'b0);
        chk("R1 dark without boundary", 24'(cyc_lit), 24'd0);

        // R4: first frame after reset has 12 digits, then the new mode
        run_to_frame(0, len);
        chk("R4 default 12 digits frame length", 24'(len), 24'(13 * 16 * TPS - 4 * 0));
        run_to_frame(0, len);
        chk("R4 code 0 frame length", 24'(len), 24'(5 * 16 * TPS));
        begin
            logic [3:0] codes [4];
            codes[0] = 4'd3; codes[1] = 4'd7; codes[2] = 4'd8; codes[3] = 4'd13;
            for (int i = 0; i < 4; i++) begin
                mode = codes[i];
                run_to_frame(0, scratch);
                run_to_frame(0, len);
                chk("R4 mode frame length", 24'(len), 24'((f_nd(codes[i]) + 1) * 16 * TPS));
            end
        end
        // R2: idle cycles between ticks do not advance the sub-slot count
        mode = 4'd1;
        run_to_frame(2, scratch);
        run_to_frame(2, len);
        chk("R2 sparse tick frame length", 24'(len), 24'(6 * 16 * TPS * 3));

        // R5: lit time of digit 0 per brightness code
        mode = 4'd8;
        run_to_frame(0, scratch);
        for (int c = 0; c < 8; c++) begin
            dim = 3'(c);
            run_to_frame(0, scratch);
            cyc_g0 = 0;
            run_to_frame(0, scratch);
            chk("R5 lit cycles for dim code", 24'(cyc_g0), 24'(f_w(3'(c)) * TPS));
        end

        // R9: display off keeps everything dark for a full frame
        on = 1'b0;
        run_to_frame(0, scratch);
        cyc_lit = 0;
        run_to_frame(0, scratch);
        chk("R9 display off dark", 24'(cyc_lit), 24'd0);
        on = 1'b1;

        // random mix, memory rewritten every cycle
        for (int i = 0; i < 15000; i++) begin
            mem[$urandom % 36] = 8'($urandom);
            if ($urandom % 400 == 0) mode = 4'($urandom);
            if ($urandom % 250 == 0) dim = 3'($urandom);
            if ($urandom % 600 == 0) on = ~on;
            if ($urandom % 5 == 0 && !on) on = 1'b1;
            step(($urandom % 4) != 0);
        end

        // R1 again: reset in the middle of a frame
        tick = 1'b0;
        rst_n = 1'b0;
        model_reset();
        @(negedge clk);
        chk("R1 mid-run reset outputs", {grid, key, frame, 10'd0}, 24'd0);
        chk("R1 mid-run reset segments", seg, 24'd0);
        rst_n = 1'b1;
        mode = 4'd2;
        run_to_frame(0, len);
        chk("R4 reset restores 12 digits", 24'(len), 24'(13 * 16 * TPS));

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not complete, actual timeout expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule